// File: doc/BRIEF.md
# Beam-Crossing Event Buffer with Trigger Readout

The block collects hit words from a front-end chip and files each one under the beam crossing in which it arrives. A crossing counter advances on every `bx_tick`. Storage is a ring of 64 crossing slots, one per crossing number, so a crossing stays available for 64 crossings of level-1 latency. Each slot keeps its own write count of up to 16 words of 24 bits. Words past that limit are dropped, and the slot is marked overflowed so that its readout can be flagged as incomplete. Every hit is also copied, one clock later, to a fast level-1 decision port together with its crossing number.

A level-1 accept names a crossing. Accepts wait in a five-entry queue and are served in arrival order. Each one produces a framed packet on a valid/ready stream: a header word, the stored words in arrival order, then a trailer word with `pkt_last` set. When the ring wraps back to a slot, that slot is emptied and reused. A slot that a queued or in-progress accept still refers to is not emptied. Hits for that crossing are discarded, and the old contents stay readable.

Top module: `bx_event_buffer`

## Requirements
- R1: After reset, `l1_valid`, `pkt_valid` and `acc_err` are 0, the crossing counter is 0, and every slot reads back with count 0 and overflow 0.
- R2: A hit word with `hit_valid`=1 is stored in the slot of the current crossing. Up to 16 words per slot are kept, and they are returned in arrival order.
- R3: A hit arriving when its slot already holds 16 words is dropped. The slot's overflow flag is set, so the packet shows count 16 and overflow 1.
- R4: Each hit is presented on `l1_valid`/`l1_data` one clock after it is taken, with `l1_bx` equal to the crossing it was stored under. This also holds when the hit is not stored.
- R5: Accepts are kept in a FIFO holding up to 5 crossing numbers. Packets come out in the order the accepts arrived, and duplicate crossing numbers are allowed.
- R6: An accept that arrives while 5 accepts are queued is discarded and produces no packet. `acc_err` is 1 during the following clock only.
- R7: A packet is a header, then count data words, then a trailer. Header: bits [23:22]=2'b10, bit 21=overflow, bits [20:16]=count, bits [5:0]=crossing, all other bits 0. The trailer is the same with bits [23:22]=2'b11. `pkt_last` is 1 only on the trailer.
- R8: While `pkt_valid`=1 and `pkt_ready`=0, `pkt_valid`, `pkt_data` and `pkt_last` hold their values.
- R9: When `bx_tick` moves the counter into a slot (mod 64), that slot is emptied, unless R10 applies. A later accept for that crossing returns only the words written since then.
- R10: If the slot being entered is named by a queued accept or by the packet being sent, it is not emptied. Hits during that crossing are discarded, and the earlier contents are still returned.
- R11: `bx_tick` advances the crossing counter by 1 mod 64 at the clock edge. A hit in the same cycle as `bx_tick` belongs to the old crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_tick | input | 1 | Advance to the next beam crossing |
| hit_valid | input | 1 | Hit word present |
| hit_data | input | 24 | Hit word |
| l1_valid | output | 1 | Forwarded hit present |
| l1_bx | output | 6 | Crossing of the forwarded hit |
| l1_data | output | 24 | Forwarded hit word |
| acc_valid | input | 1 | Level-1 accept strobe |
| acc_bx | input | 6 | Crossing named by the accept |
| acc_err | output | 1 | Accept discarded, queue full |
| pkt_valid | output | 1 | Packet word valid |
| pkt_data | output | 24 | Packet word |
| pkt_last | output | 1 | Final word (trailer) of a packet |
| pkt_ready | input | 1 | Downstream accepts the word |

## Verification
Two functions can land in the same cycle: slot reuse at a crossing tick, and readout of that same slot for a pending accept. The bench sets this up by holding `pkt_ready` low so that one accept stays in progress and a second stays queued. It then ticks the counter into both slots and sends fresh hits there. It checks that the packets released afterwards still carry the original counts, overflow flag and words, while the level-1 port still forwards the discarded hits. A second coincidence, a hit in the same cycle as a tick, is checked through the crossing number on `l1_bx` and through the slot the hit lands in.

// File: rtl/bxb_pkg.sv
package bxb_pkg;
  // readout engine states: next word to emit
  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_DATA = 2'd1,
    PK_TRL  = 2'd2
  } pk_state_t;

  localparam logic [1:0] MARK_HDR = 2'b10;
  localparam logic [1:0] MARK_TRL = 2'b11;
endpackage

// File: rtl/bxb_slot_store.sv
module bxb_slot_store #(
  parameter int NSLOT  = 64,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 24,
  localparam int BX_W  = $clog2(NSLOT),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BX_W-1:0]   wr_slot,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [BX_W-1:0]   clr_slot,
  input  logic [BX_W-1:0]   rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              rd_ovf
);
  logic [WORD_W-1:0] mem [NSLOT*DEPTH];
  logic [CNT_W-1:0]  cnt [NSLOT];
  logic [NSLOT-1:0]  ovf;
  logic              wr_ok;

  assign wr_ok = wr_en && (cnt[wr_slot] < CNT_W'(DEPTH));

  // data array: no reset, plain write port
  always_ff @(posedge clk) begin
    if (wr_ok) mem[{wr_slot, cnt[wr_slot][IDX_W-1:0]}] <= wr_data;
  end

  assign rd_data = mem[{rd_slot, rd_idx}];
  assign rd_cnt  = cnt[rd_slot];
  assign rd_ovf  = ovf[rd_slot];

  // per-slot write counters and overflow flags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) cnt[i] <= '0;
      ovf <= '0;
    end else begin
      if (wr_en) begin
        if (wr_ok) cnt[wr_slot] <= cnt[wr_slot] + 1'b1;
        else       ovf[wr_slot] <= 1'b1;
      end
      if (clr_en) begin
        cnt[clr_slot] <= '0;
        ovf[clr_slot] <= 1'b0;
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt[wr_slot] <= CNT_W'(DEPTH));
  assert_full_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cnt[wr_slot] == CNT_W'(DEPTH) && !clr_en) |=> $stable(cnt[$past(wr_slot)]));
endmodule

// File: rtl/bxb_accept_queue.sv
module bxb_accept_queue #(
  parameter int QDEPTH = 5,
  parameter int BX_W   = 6,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic [BX_W-1:0] push_bx,
  input  logic            pop,
  output logic [BX_W-1:0] head_bx,
  output logic            empty,
  output logic            err,
  input  logic [BX_W-1:0] probe_slot,
  output logic            probe_hit
);
  logic [BX_W-1:0] q [QDEPTH];
  logic [CW-1:0]   count;
  logic            full, do_push, do_pop;
  logic [CW-1:0]   wpos;

  assign full    = (count == CW'(QDEPTH));
  assign empty   = (count == '0);
  assign do_push = push_valid && !full;
  assign do_pop  = pop && !empty;
  assign wpos    = do_pop ? count - 1'b1 : count;
  assign head_bx = q[0];

  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < QDEPTH; i++)
      if (CW'(i) < count && q[i] == probe_slot) probe_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      err   <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
    end else begin
      err <= push_valid && full;
      if (do_pop)
        for (int i = 0; i < QDEPTH - 1; i++) q[i] <= q[i+1];
      if (do_push) q[wpos] <= push_bx;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_q_bound_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(QDEPTH));
  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    (push_valid && full && !pop) |=> (count == CW'(QDEPTH) && err));
endmodule

// File: rtl/bxb_packer.sv
module bxb_packer
  import bxb_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BX_W   = 6,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [BX_W-1:0]   q_head,
  output logic              q_pop,
  output logic [BX_W-1:0]   rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic              rd_ovf,
  output logic              busy,
  output logic [BX_W-1:0]   act_bx,
  output logic              pkt_valid,
  output logic [WORD_W-1:0] pkt_data,
  output logic              pkt_last,
  input  logic              pkt_ready
);
  pk_state_t        state;
  logic [BX_W-1:0]  rbx;
  logic [CNT_W-1:0] rcnt, ridx;
  logic             rovf, adv;

  function automatic logic [WORD_W-1:0] frame(input logic [1:0] mark, input logic ov,
                                              input logic [CNT_W-1:0] c, input logic [BX_W-1:0] b);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1 -: 2]     = mark;
    w[WORD_W-3]          = ov;
    w[WORD_W-4 -: CNT_W] = c;
    w[BX_W-1:0]          = b;
    return w;
  endfunction

  assign adv     = !pkt_valid || pkt_ready;
  assign q_pop   = (state == PK_IDLE) && adv && !q_empty;
  assign rd_slot = (state == PK_IDLE) ? q_head : rbx;
  assign rd_idx  = ridx[IDX_W-1:0];
  assign busy    = (state != PK_IDLE);
  assign act_bx  = rbx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PK_IDLE;
      rbx       <= '0;
      rcnt      <= '0;
      ridx      <= '0;
      rovf      <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_data  <= '0;
      pkt_last  <= 1'b0;
    end else if (adv) begin
      unique case (state)
        PK_IDLE: begin
          pkt_last <= 1'b0;
          if (!q_empty) begin
            rbx       <= q_head;
            rcnt      <= rd_cnt;
            rovf      <= rd_ovf;
            ridx      <= '0;
            pkt_valid <= 1'b1;
            pkt_data  <= frame(MARK_HDR, rd_ovf, rd_cnt, q_head);
            state     <= (rd_cnt == '0) ? PK_TRL : PK_DATA;
          end else begin
            pkt_valid <= 1'b0;
          end
        end
        PK_DATA: begin
          pkt_valid <= 1'b1;
          pkt_last  <= 1'b0;
          pkt_data  <= rd_data;
          ridx      <= ridx + 1'b1;
          if (ridx == rcnt - 1'b1) state <= PK_TRL;
        end
        default: begin
          pkt_valid <= 1'b1;
          pkt_last  <= 1'b1;
          pkt_data  <= frame(MARK_TRL, rovf, rcnt, rbx);
          state     <= PK_IDLE;
        end
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));
  assert_last_trailer_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_last) |-> (pkt_data[WORD_W-1 -: 2] == MARK_TRL));
endmodule

// File: rtl/bx_event_buffer.sv
module bx_event_buffer #(
  parameter int NSLOT  = 64,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 24,
  parameter int QDEPTH = 5,
  localparam int BX_W  = $clog2(NSLOT),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bx_tick,
  input  logic              hit_valid,
  input  logic [WORD_W-1:0] hit_data,
  output logic              l1_valid,
  output logic [BX_W-1:0]   l1_bx,
  output logic [WORD_W-1:0] l1_data,
  input  logic              acc_valid,
  input  logic [BX_W-1:0]   acc_bx,
  output logic              acc_err,
  output logic              pkt_valid,
  output logic [WORD_W-1:0] pkt_data,
  output logic              pkt_last,
  input  logic              pkt_ready
);
  logic [BX_W-1:0]   cur_bx, nxt_bx, q_head, rd_slot, act_bx;
  logic              cur_blk, locked, probe_hit, busy, q_empty, q_pop;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_data;
  logic [CNT_W-1:0]  rd_cnt;
  logic              rd_ovf;

  assign nxt_bx = cur_bx + 1'b1;
  assign locked = probe_hit || (busy && act_bx == nxt_bx);

  // crossing counter and reuse guard
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bx  <= '0;
      cur_blk <= 1'b0;
    end else if (bx_tick) begin
      cur_bx  <= nxt_bx;
      cur_blk <= locked;
    end
  end

  // level-1 forward path, one register
  always_ff @(posedge clk) begin
    if (rst) begin
      l1_valid <= 1'b0;
      l1_bx    <= '0;
      l1_data  <= '0;
    end else begin
      l1_valid <= hit_valid;
      l1_bx    <= cur_bx;
      l1_data  <= hit_data;
    end
  end

  bxb_slot_store #(.NSLOT(NSLOT), .DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(hit_valid && !cur_blk), .wr_slot(cur_bx), .wr_data(hit_data),
    .clr_en(bx_tick && !locked), .clr_slot(nxt_bx),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_cnt(rd_cnt), .rd_ovf(rd_ovf)
  );

  bxb_accept_queue #(.QDEPTH(QDEPTH), .BX_W(BX_W)) u_queue (
    .clk(clk), .rst(rst),
    .push_valid(acc_valid), .push_bx(acc_bx), .pop(q_pop),
    .head_bx(q_head), .empty(q_empty), .err(acc_err),
    .probe_slot(nxt_bx), .probe_hit(probe_hit)
  );

  bxb_packer #(.WORD_W(WORD_W), .BX_W(BX_W), .DEPTH(DEPTH)) u_packer (
    .clk(clk), .rst(rst),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_cnt(rd_cnt), .rd_ovf(rd_ovf),
    .busy(busy), .act_bx(act_bx),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .pkt_ready(pkt_ready)
  );

  assert_l1_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    hit_valid |=> (l1_valid && l1_bx == $past(cur_bx) && l1_data == $past(hit_data)));
  assert_tick_step_R11: assert property (@(posedge clk) disable iff (rst)
    bx_tick |=> (cur_bx == BX_W'($past(cur_bx) + 1'b1)));
  assert_guard_R10: assert property (@(posedge clk) disable iff (rst)
    (bx_tick && locked) |=> cur_blk);
endmodule

// File: tb/bx_event_buffer_tb.sv
`timescale 1ns/1ps
module bx_event_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bx_tick = 1'b0, hit_valid = 1'b0, acc_valid = 1'b0, pkt_ready = 1'b0;
  logic [23:0] hit_data = '0;
  logic [5:0]  acc_bx = '0;
  logic        l1_valid, acc_err, pkt_valid, pkt_last;
  logic [5:0]  l1_bx;
  logic [23:0] l1_data, pkt_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bx_event_buffer u_dut (
    .clk(clk), .rst(rst), .bx_tick(bx_tick), .hit_valid(hit_valid), .hit_data(hit_data),
    .l1_valid(l1_valid), .l1_bx(l1_bx), .l1_data(l1_data),
    .acc_valid(acc_valid), .acc_bx(acc_bx), .acc_err(acc_err),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_ready(pkt_ready)
  );

  // per crossing: hits sent, expected count, expected overflow
  localparam int VEC [5][3] = '{'{3, 3, 0}, '{0, 0, 0}, '{16, 16, 0}, '{20, 16, 1}, '{1, 1, 0}};

  function automatic logic [23:0] hw(input int bx, input int k);
    return {6'(bx), 10'd0, 8'(k)};
  endfunction

  function automatic logic [23:0] fr(input logic [1:0] m, input int ov, input int c, input int bx);
    return {m, 1'(ov), 5'(c), 10'd0, 6'(bx)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hit(input int bx, input int k, input bit tick);
    hit_valid = 1'b1; hit_data = hw(bx, k); bx_tick = tick;
    @(negedge clk);
    hit_valid = 1'b0; bx_tick = 1'b0;
    chk(l1_valid && l1_bx == 6'(bx) && l1_data == hw(bx, k), "R4", "l1 forward",
        {l1_valid, 1'b0, l1_bx, l1_data}, {1'b1, 1'b0, 6'(bx), hw(bx, k)});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bx_tick = 1'b1; @(negedge clk); bx_tick = 1'b0;
    end
  endtask

  task automatic accept(input int bx);
    acc_valid = 1'b1; acc_bx = 6'(bx);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic recv(input int ebx, input int ecnt, input int eovf, input bit stall, input string req);
    int n = 0, guard = 0;
    bit done = 0, stalled = 0, bad_data = 0, bad_last = 0, bad_hold = 0;
    logic [23:0] held = '0, hdr = '0, trl = '0;
    while (!done && guard < 300) begin
      guard++;
      if (stalled && (!pkt_valid || pkt_data !== held)) bad_hold = 1;
      pkt_ready = stall ? (guard % 3 != 0) : 1'b1;
      stalled = pkt_valid && !pkt_ready;
      held = pkt_data;
      if (pkt_valid && pkt_ready) begin
        if (n == 0) hdr = pkt_data;
        else if (pkt_last) trl = pkt_data;
        else if (pkt_data !== hw(ebx, n - 1)) bad_data = 1;
        if (pkt_last != (n == ecnt + 1)) bad_last = 1;
        if (pkt_last) done = 1;
        n++;
      end
      @(negedge clk);
    end
    pkt_ready = 1'b0;
    chk(hdr == fr(2'b10, eovf, ecnt, ebx), req, "header (R7)", hdr, fr(2'b10, eovf, ecnt, ebx));
    chk(trl == fr(2'b11, eovf, ecnt, ebx), req, "trailer (R7)", trl, fr(2'b11, eovf, ecnt, ebx));
    chk(n == ecnt + 2 && !bad_data, req, "words in order (R2)", n, ecnt + 2);
    chk(!bad_last, "R7", "last only on trailer", bad_last, 0);
    if (stall) chk(!bad_hold, "R8", "hold under backpressure", bad_hold, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!l1_valid && !pkt_valid && !acc_err, "R1", "outputs after reset",
        {l1_valid, pkt_valid, acc_err}, 0);

    // table walk: crossings 0..4 filled per VEC
    for (int v = 0; v < 5; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) hit(v, k, 1'b0);
      tick(1);
    end

    // seven accepts with the stream stalled; the seventh finds 5 queued (R6)
    for (int i = 0; i < 7; i++) begin
      accept(i < 5 ? i : (i == 5 ? 0 : 9));
      chk(acc_err == (i == 6), "R6", "acc_err pulse", acc_err, (i == 6));
    end
    @(negedge clk);
    chk(!acc_err, "R6", "acc_err single cycle", acc_err, 0);
    for (int v = 0; v < 5; v++) recv(v, VEC[v][1], VEC[v][2], v[0], v == 3 ? "R3" : "R5");
    recv(0, VEC[0][1], VEC[0][2], 1'b0, "R5");
    repeat (5) @(negedge clk);
    chk(!pkt_valid, "R6", "discarded accept gives no packet", pkt_valid, 0);

    // wrap: counter 5 -> 0 empties slot 0, slot 3 untouched yet (R9)
    tick(59);
    accept(0);
    recv(0, 0, 0, 1'b0, "R9");
    accept(3);
    recv(3, 16, 1, 1'b1, "R9");

    // reuse vs pending readout (R10)
    pkt_ready = 1'b0;
    accept(3);
    accept(4);
    tick(3);
    hit(3, 40, 1'b0);
    tick(1);
    hit(4, 50, 1'b0);
    hit(4, 51, 1'b0);
    recv(3, 16, 1, 1'b0, "R10");
    recv(4, 1, 0, 1'b0, "R10");
    tick(1);

    // hit in the tick cycle belongs to the old crossing (R11)
    hit(5, 0, 1'b1);
    hit(6, 0, 1'b0);
    accept(5);
    recv(5, 1, 0, 1'b0, "R11");
    accept(6);
    recv(6, 1, 0, 1'b0, "R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule